// File: doc/BRIEF.md
# SMBus Slave Register Port

This block is a slave-only SMBus target that lets a host read and write a small register file through a plain, synchronous register port. Both bus lines are brought into the system clock domain and sampled there. Bus events are found by watching the synchronized lines: START, repeated START and STOP. Four byte protocols are decoded: Write Byte, Read Byte, Send Byte and Receive Byte.

An internal pointer selects the register that a read returns. It keeps its value from one transaction to the next. Send Byte only moves the pointer, and Receive Byte returns the register at the pointer with no address phase. Read Byte is the same as a Send Byte followed by a Receive Byte joined by a repeated START.

The slave address is `010110s`. The low bit `s` is taken from a strap pin while reset is held. The system clock must run at least eight times faster than SCL.

Top module: `smb_regport`

## Requirements
- R1: The slave acknowledges only the 7-bit address {010110, s}, where s is the level of `strap_lsb` while `rst_n` is low. A mismatching address gets no ACK, and the block ignores the bus until the next START.
- R2: Write Byte is START, address with R/W=0, register byte, data byte, STOP. The slave ACKs all three bytes by pulling SDA low in the ninth clock. After the STOP, `reg_we` pulses with `reg_addr` equal to the register byte and `reg_wdata` equal to the data byte.
- R3: Send Byte is START, address with W, one byte, STOP. It loads the pointer with that byte and produces no write strobe.
- R4: Receive Byte is START, address with R/W=1. The slave ACKs, then drives the register at the pointer, MSB first, and releases SDA during the master's ACK or NACK bit.
- R5: Read Byte is START, address with W, register byte, repeated START, address with R. It returns the register named by the register byte, and that byte becomes the new pointer.
- R6: The pointer resets to 0x00 and keeps its value across transactions. A completed Write Byte also sets the pointer to its register byte.
- R7: Invalid shapes never write a register:
  - a third byte in a write phase is not acknowledged;
  - a START or STOP in the middle of a byte aborts the transaction and leaves the pointer unchanged;
  - a repeated START after two write bytes discards them.
- R8: `sda_oe` changes only while SCL is low, and it is asserted only in acknowledge bits and read-data bits.
- R9: `reg_we` is a single-cycle pulse, and it is never asserted while `sda_oe` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low reset; the strap is captured while it is low |
| strap_lsb | input | 1 | Level that sets the slave address LSB |
| scl_i | input | 1 | SMBus clock line as seen on the bus |
| sda_i | input | 1 | SMBus data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | REG_AW | Register index; equals the pointer |
| reg_wdata | output | BYTE_W | Write data for the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | BYTE_W | Combinational read data at `reg_addr` |

## Verification
A wrong pointer does not show up at once. It appears at the next Receive Byte, as a wrong byte on SDA, so the bench follows every pointer-changing transaction with a read. A wrong protocol state can cause a missing or extra ACK on the following byte, or it can drive SDA while SCL is high. The SCL check is made on every system clock, so such an error is reported in the cycle where it happens. A wrong byte count at the STOP appears as an unexpected or missing `reg_we` pulse within three cycles of the STOP edge. It is also caught when the register contents are compared with the bench model.

// File: rtl/smb_regport_pkg.sv
package smb_regport_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WBYTE,
      ST_WACK,
      ST_RD,
      ST_RACK,
      ST_SKIP
   } smb_state_e;

   // events seen on the synchronized bus, one system clock wide
   typedef struct packed {
      logic sda;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } smb_evt_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
   import smb_regport_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output smb_evt_t evt
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("smb_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_d, sda_d;
   logic              scl_s, sda_s;

   // synchronizer chain, one flop per stage, idle-high reset
   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_sh[0] <= 1'b1;
                  sda_sh[0] <= 1'b1;
               end else begin
                  scl_sh[0] <= scl_i;
                  sda_sh[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_sh[gi] <= 1'b1;
                  sda_sh[gi] <= 1'b1;
               end else begin
                  scl_sh[gi] <= scl_sh[gi-1];
                  sda_sh[gi] <= sda_sh[gi-1];
               end
            end
         end
      end
   endgenerate

   assign scl_s = scl_sh[STAGES-1];
   assign sda_s = sda_sh[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   always_comb begin
      evt.sda      = sda_s;
      evt.scl_rise = scl_s & ~scl_d;
      evt.scl_fall = ~scl_s & scl_d;
      evt.start    = scl_s & scl_d & sda_d & ~sda_s;
      evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
   end

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
   import smb_regport_pkg::*;
#(
   parameter int                BYTE_W  = 8,
   parameter int                ADDR_W  = 7,
   parameter int                REG_AW  = 8,
   parameter logic [ADDR_W-2:0] ADDR_HI = 6'b010110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  smb_evt_t          evt,
   input  logic              addr_lsb,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              drive_low,
   output logic [REG_AW-1:0] ptr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              wr_stb
);

   localparam int                CNT_W    = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

   generate
      if (ADDR_W != BYTE_W - 1) begin : g_bad_addr
         $error("smb_proto_fsm: ADDR_W must be BYTE_W-1");
      end
      if (REG_AW > BYTE_W) begin : g_bad_reg
         $error("smb_proto_fsm: REG_AW must not exceed BYTE_W");
      end
   endgenerate

   smb_state_e          state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [BYTE_W-1:0]   sh_q, cmd_q, dat_q;
   logic [1:0]          nb_q;
   logic                rw_q, drv_q, we_q;
   logic [REG_AW-1:0]   ptr_q;
   logic                at_gap, addr_hit;

   // a write phase is at a byte gap when at most the first SCL rise of
   // the next byte has been seen (STOP and repeated START both need one)
   assign at_gap   = (state_q == ST_WBYTE) && (cnt_q <= CNT_ONE);
   assign addr_hit = (sh_q[BYTE_W-1 -: ADDR_W] == {ADDR_HI, addr_lsb});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         sh_q    <= '0;
         cmd_q   <= '0;
         dat_q   <= '0;
         nb_q    <= '0;
         rw_q    <= 1'b0;
         drv_q   <= 1'b0;
         ptr_q   <= '0;
         we_q    <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (evt.start) begin
            if (at_gap && nb_q == 2'd1) ptr_q <= cmd_q[REG_AW-1:0];
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            nb_q    <= '0;
            drv_q   <= 1'b0;
         end else if (evt.stop) begin
            if (at_gap && nb_q == 2'd1) begin
               ptr_q <= cmd_q[REG_AW-1:0];
            end else if (at_gap && nb_q == 2'd2) begin
               ptr_q <= cmd_q[REG_AW-1:0];
               we_q  <= 1'b1;
            end
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            nb_q    <= '0;
            drv_q   <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR: begin
                  if (evt.scl_rise && cnt_q != CNT_FULL) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], evt.sda};
                     cnt_q <= cnt_q + CNT_ONE;
                  end else if (evt.scl_fall && cnt_q == CNT_FULL) begin
                     if (addr_hit) begin
                        rw_q    <= sh_q[0];
                        drv_q   <= 1'b1;
                        state_q <= ST_AACK;
                     end else begin
                        state_q <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: begin
                  if (evt.scl_fall) begin
                     cnt_q <= '0;
                     if (rw_q) begin
                        sh_q    <= rd_data;
                        drv_q   <= ~rd_data[BYTE_W-1];
                        state_q <= ST_RD;
                     end else begin
                        drv_q   <= 1'b0;
                        nb_q    <= '0;
                        state_q <= ST_WBYTE;
                     end
                  end
               end
               ST_WBYTE: begin
                  if (evt.scl_rise && cnt_q != CNT_FULL) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], evt.sda};
                     cnt_q <= cnt_q + CNT_ONE;
                  end else if (evt.scl_fall && cnt_q == CNT_FULL) begin
                     if (nb_q == 2'd0) begin
                        cmd_q   <= sh_q;
                        nb_q    <= 2'd1;
                        drv_q   <= 1'b1;
                        state_q <= ST_WACK;
                     end else if (nb_q == 2'd1) begin
                        dat_q   <= sh_q;
                        nb_q    <= 2'd2;
                        drv_q   <= 1'b1;
                        state_q <= ST_WACK;
                     end else begin
                        state_q <= ST_SKIP;
                     end
                  end
               end
               ST_WACK: begin
                  if (evt.scl_fall) begin
                     drv_q   <= 1'b0;
                     cnt_q   <= '0;
                     state_q <= ST_WBYTE;
                  end
               end
               ST_RD: begin
                  if (evt.scl_rise && cnt_q != CNT_FULL) begin
                     cnt_q <= cnt_q + CNT_ONE;
                  end else if (evt.scl_fall) begin
                     if (cnt_q == CNT_FULL) begin
                        drv_q   <= 1'b0;
                        state_q <= ST_RACK;
                     end else begin
                        sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                        drv_q <= ~sh_q[BYTE_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (evt.scl_fall) state_q <= ST_SKIP;
               end
               default: ;
            endcase
         end
      end
   end

   assign drive_low = drv_q;
   assign ptr       = ptr_q;
   assign wr_data   = dat_q;
   assign wr_stb    = we_q;

endmodule

// File: rtl/smb_regport.sv
module smb_regport
   import smb_regport_pkg::*;
#(
   parameter int                BYTE_W      = 8,
   parameter int                ADDR_W      = 7,
   parameter int                REG_AW      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-2:0] ADDR_HI     = 6'b010110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_lsb,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [REG_AW-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [BYTE_W-1:0] reg_rdata
);

   smb_evt_t evt;
   logic     lsb_q;

   // strap captured for as long as reset is held, then frozen
   always_ff @(posedge clk) begin
      if (!rst_n) lsb_q <= strap_lsb;
   end

   smb_line_sync #(
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .evt   (evt)
   );

   smb_proto_fsm #(
      .BYTE_W  (BYTE_W),
      .ADDR_W  (ADDR_W),
      .REG_AW  (REG_AW),
      .ADDR_HI (ADDR_HI)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .addr_lsb  (lsb_q),
      .rd_data   (reg_rdata),
      .drive_low (sda_oe),
      .ptr       (reg_addr),
      .wr_data   (reg_wdata),
      .wr_stb    (reg_we)
   );

endmodule

// File: rtl/smb_regport_chk.sv
module smb_regport_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_i,
   input logic sda_oe,
   input logic reg_we
);

   // R8
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   // R9
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R9
   we_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !sda_oe);

   // R2
   we_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (scl_i && sda_i));

endmodule

bind smb_regport smb_regport_chk chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .scl_i  (scl_i),
   .sda_i  (sda_i),
   .sda_oe (sda_oe),
   .reg_we (reg_we)
);

// File: tb/smb_regport_tb_top.sv
`timescale 1ns/1ps
module smb_regport_tb_top;

   localparam int QTR = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap = 1'b1;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe, reg_we;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic       sda_bus;

   logic [7:0] mem   [256];
   logic [7:0] model [256];
   logic [7:0] mptr;
   int         vectors = 0, errs = 0, we_seen = 0, exp_we = 0;
   logic       may_drive = 1'b0;
   logic       prev_oe = 1'b0;
   logic [6:0] my_addr;

   always #2.5 clk = ~clk;

   assign sda_bus   = sda_m & ~sda_oe;
   assign reg_rdata = mem[reg_addr];

   smb_regport dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_lsb (strap),
      .scl_i     (scl_m),
      .sda_i     (sda_bus),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata)
   );

   // the register file the port serves
   always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

   // per-clock line discipline compare
   always @(negedge clk) begin
      if (rst_n) begin
         vectors++;
         if (sda_oe !== prev_oe && scl_m) begin
            errs++;
            $display("FAIL R8: sda_oe changed to %0b while SCL high (expected no change)", sda_oe);
         end
         if (sda_oe && !may_drive) begin
            errs++;
            $display("FAIL R8: sda_oe=1 outside ack/read bit (expected 0)");
         end
         if (reg_we) we_seen++;
      end
      prev_oe = sda_oe;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic q();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; q(); may_drive = 1'b0;
      scl_m = 1'b1; q();
      sda_m = 1'b0; q();
      scl_m = 1'b0; q();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; q(); may_drive = 1'b0;
      scl_m = 1'b1; q();
      sda_m = 1'b1; q();
   endtask

   task automatic wbit(input logic b);
      sda_m = b; q();
      scl_m = 1'b1; q(); q();
      scl_m = 1'b0;
   endtask

   task automatic wbyte(input logic [7:0] v, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = v[i]; q();
         if (i == 7) may_drive = 1'b0;
         scl_m = 1'b1; q(); q();
         if (i == 0) may_drive = 1'b1;
         scl_m = 1'b0; q();
      end
      sda_m = 1'b1; q();
      scl_m = 1'b1; q();
      ack = !sda_bus; q();
      scl_m = 1'b0; q();
   endtask

   task automatic rbyte(input bit mack, output logic [7:0] v);
      may_drive = 1'b1;
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         q(); scl_m = 1'b1; q();
         v[i] = sda_bus; q();
         scl_m = 1'b0; q();
      end
      sda_m = !mack; q();
      may_drive = 1'b0;
      scl_m = 1'b1; q(); q();
      scl_m = 1'b0; q();
   endtask

   task automatic do_write(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                           input bit expect_ok, input string tag);
      bit a0, a1, a2;
      bus_start();
      wbyte({a, 1'b0}, a0);
      wbyte(r, a1);
      wbyte(d, a2);
      bus_stop();
      q();
      chk({a0, a1, a2} == {3{expect_ok}}, tag, {a0, a1, a2}, {3{expect_ok}});
      if (expect_ok) begin
         model[r] = d;
         mptr = r;
         exp_we++;
      end
   endtask

   task automatic do_send(input logic [7:0] r, input string tag);
      bit a0, a1;
      bus_start();
      wbyte({my_addr, 1'b0}, a0);
      wbyte(r, a1);
      bus_stop();
      q();
      chk(a0 && a1, tag, {a0, a1}, 2'b11);
      mptr = r;
   endtask

   task automatic do_recv(input string tag);
      bit a0;
      logic [7:0] v;
      bus_start();
      wbyte({my_addr, 1'b1}, a0);
      rbyte(1'b0, v);
      bus_stop();
      q();
      chk(a0 && v == model[mptr], tag, v, model[mptr]);
   endtask

   task automatic do_readbyte(input logic [7:0] r, input string tag);
      bit a0, a1, a2;
      logic [7:0] v;
      bus_start();
      wbyte({my_addr, 1'b0}, a0);
      wbyte(r, a1);
      bus_start();
      wbyte({my_addr, 1'b1}, a2);
      rbyte(1'b0, v);
      bus_stop();
      q();
      mptr = r;
      chk(a0 && a1 && a2 && v == model[r], tag, v, model[r]);
   endtask

   task automatic check_mem(input string tag);
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== model[i]) bad++;
      chk(bad == 0, tag, bad, 0);
      chk(we_seen == exp_we, tag, we_seen, exp_we);
   endtask

   task automatic do_reset(input logic s);
      rst_n = 1'b0;
      strap = s;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      strap = ~s;   // strap must be ignored after reset
      mptr = 8'h00;
      my_addr = {6'b010110, s};
      repeat (3) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: run did not complete (expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin
      bit ack;
      for (int i = 0; i < 256; i++) begin
         mem[i]   = 8'(i * 7 + 3);
         model[i] = 8'(i * 7 + 3);
      end
      do_reset(1'b1);
      // reset state: bus released, no strobe (R8, R9)
      chk(sda_oe == 1'b0 && reg_we == 1'b0, "R9 reset", {sda_oe, reg_we}, 0);
      chk(reg_addr == 8'h00, "R6 reset pointer", reg_addr, 0);

      // R4, R6: receive byte from pointer 0 after reset
      do_recv("R4 recv at reset pointer");

      // R2: write byte, then R6: pointer follows the write
      do_write(my_addr, 8'h12, 8'h3C, 1'b1, "R2 write acks");
      check_mem("R2 write result");
      do_recv("R6 pointer after write");
      do_write(my_addr, 8'hF0, 8'h81, 1'b1, "R2 write acks 2");
      check_mem("R2 write result 2");

      // R3: send byte only moves pointer
      do_send(8'h40, "R3 send acks");
      check_mem("R3 no write on send");
      do_recv("R3 recv after send");
      do_recv("R6 pointer persists");

      // R5: read byte
      do_readbyte(8'h7E, "R5 read byte");
      do_recv("R5 pointer from read byte");
      do_readbyte(8'hF0, "R5 read written reg");

      // R1: wrong address ignored
      do_write(7'h2C, 8'h05, 8'hEE, 1'b0, "R1 wrong addr nack");
      check_mem("R1 no write on wrong addr");
      do_recv("R1 pointer untouched");

      // R7: third byte nacked, no write
      bus_start();
      wbyte({my_addr, 1'b0}, ack);
      wbyte(8'h22, ack);
      wbyte(8'h55, ack);
      wbyte(8'h66, ack);
      chk(!ack, "R7 third byte nack", ack, 0);
      bus_stop(); q();
      check_mem("R7 no write on long write");

      // R7: STOP inside data byte aborts
      bus_start();
      wbyte({my_addr, 1'b0}, ack);
      wbyte(8'h33, ack);
      wbit(1'b1); wbit(1'b0); wbit(1'b1);
      bus_stop(); q();
      check_mem("R7 no write on mid-byte stop");
      do_recv("R7 pointer unchanged by abort");

      // R7: repeated START after two bytes discards them
      bus_start();
      wbyte({my_addr, 1'b0}, ack);
      wbyte(8'h44, ack);
      wbyte(8'h99, ack);
      bus_start();
      wbyte({my_addr, 1'b1}, ack);
      begin
         logic [7:0] v;
         rbyte(1'b0, v);
         chk(v == model[mptr], "R7 sr after two bytes", v, model[mptr]);
      end
      bus_stop(); q();
      check_mem("R7 no write on restart");

      // R1: strap low on a new reset
      do_reset(1'b0);
      do_write(7'h2D, 8'h10, 8'h77, 1'b0, "R1 old address nack");
      do_write(7'h2C, 8'h10, 8'h77, 1'b1, "R1 strap-low address ack");
      check_mem("R1 write with strap low");
      do_recv("R6 pointer after second reset write");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

endmodule